// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. A transmitter serialises words from a four-entry queue onto one output line. At the same time, a receiver rebuilds words from the input line and places them in a second four-entry queue. Each frame has a low start bit, the data bits with the least significant bit first, and one high stop bit. The data field is 8 or 9 bits wide. A single rate generator serves both directions. It produces sixteen sample ticks per bit, and its divisor has a 13-bit whole part and a 3-bit fraction.

The host writes words into the transmit queue and reads received words from the head of the receive queue. The receive queue is first-word-fall-through. Configuration arrives as plain level inputs. Three sticky flags report errors: a noisy bit, a bad stop bit and a lost word. A single pulse clears all three flags.

The receiver can be put to sleep so that it ignores traffic that is not meant for it. It wakes in one of two ways. In address mode it wakes on a frame whose ninth bit is set. In idle mode it wakes after one full character time of quiet line.

Top module: `serial_xcvr`

## Requirements
- R1: After reset the transmit line is high, both queues are empty, `tx_full_o` is low, all three flags are low and the receiver is awake.
- R2: A transmitted frame is one low start bit, then the data bits least significant first, then one high stop bit. Each bit lasts 16 sample ticks, and each tick lasts `div_i` clocks (a value of 0 counts as 1).
- R3: With fraction `frac_i` = k, k out of every 8 bit periods are one clock longer. A 10-bit frame at `div_i` = 3 and k = 4 therefore lasts exactly 485 clocks, where k = 0 gives 480.
- R4: The transmit queue holds four words and sends them as back-to-back frames. `tx_full_o` is high while four words wait, and a push made while it is high is discarded.
- R5: Words sent in either data width arrive in order at the head of the receive queue, while both directions run at once. In 8-bit mode (`nine_bit_i` = 0), bit 8 of `rx_data_o` reads 0.
- R6: The receive queue holds four words. A word that completes while the queue is full and not being popped is dropped, `overrun_o` is set, and the four stored words are kept.
- R7: Each bit is sampled at ticks 7, 8 and 9 of its period and the majority value is kept. If the three samples disagree, `noise_o` is set and the word is still stored with the majority values.
- R8: A stop bit that samples low sets `frame_err_o`, and the word is still stored.
- R9: With `wake_addr_i` = 1 and 9-bit frames, a sleeping receiver discards frames whose bit 8 is 0. A frame with bit 8 = 1 wakes the receiver and is stored.
- R10: With `wake_addr_i` = 0, a sleeping receiver discards frames. It wakes after 16 times (frame bit count) ticks of uninterrupted high line, counted from the sleep request or from the end of the last frame.
- R11: A pulse on `flag_clr_i` clears `noise_o`, `frame_err_o` and `overrun_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_i | input | 13 | Whole part of the clocks per sample tick |
| frac_i | input | 3 | Fraction in eighths of a clock per bit period |
| nine_bit_i | input | 1 | 1 selects 9-bit data, 0 selects 8-bit data |
| wake_addr_i | input | 1 | Wake source: 1 = address mark, 0 = idle line |
| sleep_req_i | input | 1 | Pulse that puts the receiver to sleep |
| tx_data_i | input | 9 | Word to transmit |
| tx_push_i | input | 1 | Writes `tx_data_i` into the transmit queue |
| tx_full_o | output | 1 | Transmit queue holds four words |
| tx_empty_o | output | 1 | Transmit queue is empty |
| rx_data_o | output | 9 | Oldest received word |
| rx_pop_i | input | 1 | Removes the oldest received word |
| rx_empty_o | output | 1 | Receive queue is empty |
| flag_clr_i | input | 1 | Clears the three error flags |
| noise_o | output | 1 | Sticky flag: three samples of a bit disagreed |
| frame_err_o | output | 1 | Sticky flag: stop bit sampled low |
| overrun_o | output | 1 | Sticky flag: word dropped because the receive queue was full |
| rx_asleep_o | output | 1 | Receiver is sleeping |
| txd_o | output | 1 | Serial output line |
| rxd_i | input | 1 | Serial input line |

## Verification
Two things can land on the same clock edge. The first is the receiver writing a finished word while the host pops the receive queue. The second is the transmitter pulling its next word while the host pushes the transmit queue. The bench provokes both by running randomised loopback batches, with one process pushing and another popping at once, over random divisors, fractions and data widths. It judges the result by comparing every received word, in order, against the list of words sent, and by checking that no overrun appears during those batches.

// File: rtl/sx_pkg.sv
package sx_pkg;
    localparam int OVS   = 16;
    localparam int OVS_W = 4;

    typedef struct packed {
        logic noise;
        logic framing;
        logic overrun;
    } sx_flags_t;
endpackage

// File: rtl/sx_fifo.sv
module sx_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] wdata_i,
    input  logic         pop_i,
    output logic [W-1:0] rdata_o,
    output logic         empty_o,
    output logic         full_o,
    output logic         wr_ok_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           wp;
        logic [AW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } fifo_s;

    fifo_s q, d;
    logic  do_pop, do_push;

    assign empty_o = (q.cnt == '0);
    assign full_o  = (q.cnt == CW'(DEPTH));
    assign rdata_o = q.mem[q.rp];
    assign do_pop  = pop_i && !empty_o;
    assign wr_ok_o = !full_o || do_pop;
    assign do_push = push_i && wr_ok_o;

    always_comb begin
        d = q;
        if (do_push) begin
            d.mem[q.wp] = wdata_i;
            d.wp = (q.wp == AW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_pop) begin
            d.rp = (q.rp == AW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R6 / R4: a push into a full queue without a pop leaves it full
    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i) |=> full_o);

    // R5: popping an empty queue with no push keeps it empty
    p_empty_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/sx_baud.sv
module sx_baud
    import sx_pkg::*;
#(
    parameter int DIV_W  = 13,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              tick_o
);
    typedef struct packed {
        logic [DIV_W:0]    cnt;
        logic [OVS_W-1:0]  slot;
        logic [FRAC_W-1:0] acc;
        logic              stretch;
        logic              tick;
    } baud_s;

    baud_s q, d;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W:0]   lim;
    logic [FRAC_W:0]  sum;

    assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    assign lim     = {1'b0, div_eff} - (DIV_W+1)'(1) + (DIV_W+1)'(q.stretch);
    assign sum     = {1'b0, q.acc} + {1'b0, frac_i};
    assign tick_o  = q.tick;

    always_comb begin
        d = q;
        d.tick = 1'b0;
        if (q.cnt >= lim) begin
            d.cnt     = '0;
            d.tick    = 1'b1;
            d.stretch = 1'b0;
            d.slot    = q.slot + 1'b1;
            if (q.slot == OVS_W'(OVS - 1)) begin
                d.acc     = sum[FRAC_W-1:0];
                d.stretch = sum[FRAC_W];
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R3: ticks never come on adjacent clocks when the divisor exceeds one
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.tick && div_i > DIV_W'(1)) |=> (!q.tick || div_i <= DIV_W'(1)));
endmodule

// File: rtl/sx_tx.sv
module sx_tx
    import sx_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          nine_i,
    input  logic          q_empty_i,
    input  logic [DW-1:0] q_data_i,
    output logic          q_pop_o,
    output logic          line_o
);
    localparam int SW = DW + 2;
    localparam int LW = $clog2(SW + 1);

    typedef struct packed {
        logic             busy;
        logic [SW-1:0]    sh;
        logic [LW-1:0]    left;
        logic [OVS_W-1:0] ph;
        logic             line;
    } tx_s;

    tx_s  q, d;
    logic done;

    assign line_o = q.line;

    always_comb begin
        d       = q;
        q_pop_o = 1'b0;
        done    = 1'b0;
        if (tick_i) begin
            if (q.busy) begin
                d.ph = q.ph + 1'b1;
                if (q.ph == OVS_W'(OVS - 1)) begin
                    d.sh   = {1'b1, q.sh[SW-1:1]};
                    d.left = q.left - 1'b1;
                    if (q.left == LW'(1)) begin
                        d.busy = 1'b0;
                        done   = 1'b1;
                    end
                end
            end
            if ((!q.busy || done) && !q_empty_i) begin
                q_pop_o = 1'b1;
                d.busy  = 1'b1;
                d.ph    = '0;
                if (nine_i) begin
                    d.left = LW'(DW + 2);
                    d.sh   = {1'b1, q_data_i, 1'b0};
                end else begin
                    d.left = LW'(DW + 1);
                    d.sh   = {2'b11, q_data_i[DW-2:0], 1'b0};
                end
            end
        end
        d.line = d.busy ? d.sh[0] : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, sh: '1, left: '0, ph: '0, line: 1'b1};
        else        q <= d;
    end

    // R2: every frame opens with a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> !q.line);

    // R2: the last bit driven before going idle is a high stop bit
    p_stop_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> $past(q.line));
endmodule

// File: rtl/sx_rx.sv
module sx_rx
    import sx_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          line_i,
    input  logic          nine_i,
    input  logic          wake_addr_i,
    input  logic          sleep_req_i,
    input  logic          clr_i,
    input  logic          fifo_wr_ok_i,
    output logic          push_o,
    output logic [DW-1:0] word_o,
    output sx_flags_t     flags_o,
    output logic          asleep_o
);
    localparam int BW     = $clog2(DW + 3);
    localparam int IDLE_W = $clog2(OVS * (DW + 2) + 1);

    typedef struct packed {
        logic              s1;
        logic              s2;
        logic              active;
        logic [OVS_W-1:0]  ph;
        logic [BW-1:0]     bitn;
        logic [DW-1:0]     sh;
        logic [1:0]        smp;
        logic              noisy;
        logic [IDLE_W-1:0] idle;
        logic              sleep;
        sx_flags_t         flg;
    } rx_s;

    rx_s q, d;
    logic              line, maj, nz, frame_done_c, keep_c;
    logic [BW-1:0]     last_bit;
    logic [IDLE_W-1:0] char_ticks;

    assign line       = q.s2;
    assign last_bit   = nine_i ? BW'(DW + 1) : BW'(DW);
    assign char_ticks = nine_i ? IDLE_W'(OVS * (DW + 2)) : IDLE_W'(OVS * (DW + 1));
    assign maj        = (q.smp[0] & q.smp[1]) | (q.smp[0] & line) | (q.smp[1] & line);
    assign nz         = !((q.smp[0] == q.smp[1]) && (q.smp[1] == line));
    assign flags_o    = q.flg;
    assign asleep_o   = q.sleep;

    always_comb begin
        d            = q;
        d.s1         = line_i;
        d.s2         = q.s1;
        push_o       = 1'b0;
        word_o       = nine_i ? q.sh : {1'b0, q.sh[DW-1:1]};
        frame_done_c = 1'b0;
        keep_c       = 1'b0;
        if (clr_i) d.flg = '0;
        if (tick_i) begin
            if (!q.active) begin
                if (!line) begin
                    d.active = 1'b1;
                    d.ph     = OVS_W'(1);
                    d.bitn   = '0;
                    d.noisy  = 1'b0;
                    d.idle   = '0;
                end else if (q.idle != '1) begin
                    d.idle = q.idle + 1'b1;
                end
            end else begin
                d.ph = q.ph + 1'b1;
                if (q.ph == OVS_W'(7)) d.smp[0] = line;
                if (q.ph == OVS_W'(8)) d.smp[1] = line;
                if (q.ph == OVS_W'(9)) begin
                    if (q.bitn == '0) begin
                        if (maj) d.active = 1'b0;
                        else     d.noisy  = nz;
                    end else if (q.bitn == last_bit) begin
                        d.active     = 1'b0;
                        d.idle       = '0;
                        frame_done_c = 1'b1;
                        keep_c       = !q.sleep;
                        if (q.sleep && wake_addr_i && nine_i && word_o[DW-1]) begin
                            d.sleep = 1'b0;
                            keep_c  = 1'b1;
                        end
                        if (keep_c) begin
                            if (fifo_wr_ok_i) push_o = 1'b1;
                            else              d.flg.overrun = 1'b1;
                            if (q.noisy || nz) d.flg.noise   = 1'b1;
                            if (!maj)          d.flg.framing = 1'b1;
                        end
                    end else begin
                        d.sh    = {maj, q.sh[DW-1:1]};
                        d.noisy = q.noisy | nz;
                    end
                end
                if (q.ph == OVS_W'(OVS - 1)) d.bitn = q.bitn + 1'b1;
            end
        end
        if (q.sleep && !wake_addr_i && q.idle >= char_ticks) d.sleep = 1'b0;
        if (sleep_req_i) begin
            d.sleep = 1'b1;
            d.idle  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.s1 <= 1'b1;
            q.s2 <= 1'b1;
        end else begin
            q <= d;
        end
    end

    // R6: a finished word that finds no room raises the overrun flag
    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done_c && keep_c && !fifo_wr_ok_i) |=> q.flg.overrun);

    // R9 / R10: a sleeping receiver stores nothing unless an address mark may wake it
    p_sleep_nopush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.sleep && !(wake_addr_i && nine_i)) |-> !push_o);

    // R11: a clear pulse with no frame finishing leaves all flags low
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !frame_done_c) |=> (q.flg == '0));
endmodule

// File: rtl/serial_xcvr.sv
module serial_xcvr
    import sx_pkg::*;
#(
    parameter int DIV_W  = 13,
    parameter int FRAC_W = 3,
    parameter int DW     = 9,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic              nine_bit_i,
    input  logic              wake_addr_i,
    input  logic              sleep_req_i,
    input  logic [DW-1:0]     tx_data_i,
    input  logic              tx_push_i,
    output logic              tx_full_o,
    output logic              tx_empty_o,
    output logic [DW-1:0]     rx_data_o,
    input  logic              rx_pop_i,
    output logic              rx_empty_o,
    input  logic              flag_clr_i,
    output logic              noise_o,
    output logic              frame_err_o,
    output logic              overrun_o,
    output logic              rx_asleep_o,
    output logic              txd_o,
    input  logic              rxd_i
);
    logic          tick, tx_pop, tx_wr_ok;
    logic [DW-1:0] tx_head;
    logic          rx_push, rx_wr_ok, rx_full;
    logic [DW-1:0] rx_word;
    sx_flags_t     flags;

    assign noise_o     = flags.noise;
    assign frame_err_o = flags.framing;
    assign overrun_o   = flags.overrun;

    sx_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .div_i(div_i), .frac_i(frac_i), .tick_o(tick)
    );

    sx_fifo #(.W(DW), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push_i(tx_push_i), .wdata_i(tx_data_i),
        .pop_i(tx_pop), .rdata_o(tx_head), .empty_o(tx_empty_o),
        .full_o(tx_full_o), .wr_ok_o(tx_wr_ok)
    );

    sx_tx #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .nine_i(nine_bit_i),
        .q_empty_i(tx_empty_o), .q_data_i(tx_head), .q_pop_o(tx_pop), .line_o(txd_o)
    );

    sx_rx #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .line_i(rxd_i), .nine_i(nine_bit_i),
        .wake_addr_i(wake_addr_i), .sleep_req_i(sleep_req_i), .clr_i(flag_clr_i),
        .fifo_wr_ok_i(rx_wr_ok), .push_o(rx_push), .word_o(rx_word),
        .flags_o(flags), .asleep_o(rx_asleep_o)
    );

    sx_fifo #(.W(DW), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push_i(rx_push), .wdata_i(rx_word),
        .pop_i(rx_pop_i), .rdata_o(rx_data_o), .empty_o(rx_empty_o),
        .full_o(rx_full), .wr_ok_o(rx_wr_ok)
    );

    // R4: the transmit queue never accepts a word while it reports full
    p_tx_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_full_o && !tx_pop) |-> !tx_wr_ok);
endmodule

// File: tb/serial_xcvr_bench.sv
module serial_xcvr_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] div = 13'd3;
    logic [2:0]  frac = 3'd0;
    logic        nine = 1'b0, wake_addr = 1'b0, sleep_req = 1'b0;
    logic [8:0]  tx_data = '0;
    logic        tx_push = 1'b0, rx_pop = 1'b0, flag_clr = 1'b0;
    logic        tx_full, tx_empty, rx_empty, noise, frame_err, overrun, asleep, txd;
    logic [8:0]  rx_data;
    logic        loop_en = 1'b0, line_drv = 1'b1;
    logic        rxd;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 1'b0;

    assign rxd = loop_en ? txd : line_drv;

    always #2 clk = ~clk;

    serial_xcvr u_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .div_i(div), .frac_i(frac), .nine_bit_i(nine),
        .wake_addr_i(wake_addr), .sleep_req_i(sleep_req), .tx_data_i(tx_data),
        .tx_push_i(tx_push), .tx_full_o(tx_full), .tx_empty_o(tx_empty),
        .rx_data_o(rx_data), .rx_pop_i(rx_pop), .rx_empty_o(rx_empty),
        .flag_clr_i(flag_clr), .noise_o(noise), .frame_err_o(frame_err),
        .overrun_o(overrun), .rx_asleep_o(asleep), .txd_o(txd), .rxd_i(rxd)
    );

    function automatic logic [8:0] expect_word(input logic [8:0] w, input logic n9);
        return n9 ? w : {1'b0, w[7:0]};
    endfunction

    function automatic int frame_clocks(input int dv, input int bits, input int k);
        return 16 * bits * dv + (bits * k) / 8;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_word(input logic [8:0] w);
        while (tx_full) @(negedge clk);
        tx_data = w;
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
    endtask

    task automatic pop_word(output logic [8:0] w, output bit ok);
        int t = 0;
        while (rx_empty && t < 6000) begin
            @(negedge clk);
            t++;
        end
        ok = !rx_empty;
        w = rx_data;
        if (ok) begin
            rx_pop = 1'b1;
            @(negedge clk);
            rx_pop = 1'b0;
        end
    endtask

    task automatic wait_fall();
        int t = 0;
        while (txd == 1'b1 && t < 6000) begin
            @(negedge clk);
            t++;
        end
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    // drives one 8-bit frame on the receive line; glitch inverts one sample tick of bit gbit
    task automatic drive_frame(input logic [7:0] v, input logic stop_v, input int gbit, input int dv);
        for (int p = 0; p < 10; p++) begin
            logic b;
            b = (p == 0) ? 1'b0 : (p == 9) ? stop_v : v[p-1];
            line_drv = b;
            if (p == gbit) begin
                clocks(8 * dv - 2);
                line_drv = ~b;
                clocks(dv);
                line_drv = b;
                clocks(7 * dv + 2);
            end else begin
                clocks(16 * dv);
            end
        end
        line_drv = 1'b1;
        clocks(16 * dv * 3);
    endtask

    initial begin
        logic [8:0] w;
        bit ok;
        int dummy;
        dummy = $urandom(32'd2718);
        clocks(3);
        rst_n = 1'b1;
        clocks(2);

        // R1 reset state
        chk(txd == 1'b1, "R1 line idle", txd, 1);
        chk(rx_empty && tx_empty && !tx_full, "R1 queues empty", {rx_empty, tx_empty, tx_full}, 3'b110);
        chk({noise, frame_err, overrun, asleep} == 4'b0, "R1 flags low",
            {noise, frame_err, overrun, asleep}, 0);

        // R2 frame shape, 8-bit, div 3
        begin
            logic [9:0] got, exp;
            exp = {1'b1, 8'hA5, 1'b0};
            push_word(9'h0A5);
            wait_fall();
            clocks(24);
            for (int i = 0; i < 10; i++) begin
                got[i] = txd;
                if (i < 9) clocks(48);
            end
            chk(got == exp, "R2 bit sequence", got, exp);
            clocks(200);
        end

        // R3 frame length with fraction 0 and 4
        for (int k = 0; k <= 4; k += 4) begin
            int c;
            bit seen_hi;
            frac = 3'(k);
            clocks(600);
            push_word(9'h000);
            push_word(9'h000);
            wait_fall();
            c = 0;
            seen_hi = 1'b0;
            while (!(seen_hi && txd == 1'b0) && c < 5000) begin
                @(negedge clk);
                c++;
                if (txd) seen_hi = 1'b1;
            end
            chk(c == frame_clocks(3, 10, k), "R3 frame clocks", c, frame_clocks(3, 10, k));
            clocks(600);
        end
        frac = 3'd0;

        // R4 queue depth, full flag, dropped fifth push, back-to-back order
        loop_en = 1'b1;
        clocks(100);
        push_word(9'h011);
        wait_fall();
        push_word(9'h022);
        push_word(9'h033);
        push_word(9'h044);
        push_word(9'h055);
        chk(tx_full == 1'b1, "R4 full at four", tx_full, 1);
        tx_data = 9'h066;
        tx_push = 1'b1;
        @(negedge clk);
        tx_push = 1'b0;
        for (int i = 0; i < 5; i++) begin
            logic [8:0] e;
            e = 9'(17 * (i + 1));
            pop_word(w, ok);
            chk(ok && w == e, "R4 word order", w, e);
        end
        clocks(1500);
        chk(rx_empty == 1'b1, "R4 push while full ignored", rx_empty, 1);

        // R5 random loopback batches, concurrent push and pop
        for (int bt = 0; bt < 3; bt++) begin
            logic [8:0] words [8];
            nine = (bt == 1);
            div  = 13'($urandom_range(2, 4));
            frac = 3'($urandom_range(0, 7));
            for (int i = 0; i < 8; i++) words[i] = 9'($urandom_range(0, 511));
            clocks(800);
            pulse_clr();
            fork
                begin
                    for (int i = 0; i < 8; i++) push_word(words[i]);
                end
                begin
                    for (int i = 0; i < 8; i++) begin
                        logic [8:0] rw;
                        bit rok;
                        pop_word(rw, rok);
                        chk(rok && rw == expect_word(words[i], nine), "R5 loopback word",
                            rw, expect_word(words[i], nine));
                    end
                end
            join
            chk({noise, frame_err, overrun} == 3'b0, "R5 no error flags",
                {noise, frame_err, overrun}, 0);
        end
        nine = 1'b0;
        div  = 13'd3;
        frac = 3'd0;
        clocks(800);

        // R6 overrun: five words, no pops
        pulse_clr();
        for (int i = 0; i < 5; i++) push_word(9'(8'h30 + i));
        while (!tx_empty) @(negedge clk);
        clocks(700);
        chk(overrun == 1'b1, "R6 overrun flag", overrun, 1);
        for (int i = 0; i < 4; i++) begin
            pop_word(w, ok);
            chk(ok && w == 9'(8'h30 + i), "R6 kept words", w, 9'(8'h30 + i));
        end
        chk(rx_empty == 1'b1, "R6 fifth dropped", rx_empty, 1);

        // R11 clear
        pulse_clr();
        chk({noise, frame_err, overrun} == 3'b0, "R11 flags cleared", {noise, frame_err, overrun}, 0);

        // R7 majority and noise, bench-driven line at div 8
        loop_en = 1'b0;
        div = 13'd8;
        clocks(400);
        drive_frame(8'h3C, 1'b1, -1, 8);
        pop_word(w, ok);
        chk(ok && w == 9'h03C, "R7 clean word", w, 9'h03C);
        chk(noise == 1'b0, "R7 no noise on clean frame", noise, 0);
        drive_frame(8'h3C, 1'b1, 3, 8);
        pop_word(w, ok);
        chk(ok && w == 9'h03C, "R7 majority value", w, 9'h03C);
        chk(noise == 1'b1 && frame_err == 1'b0, "R7 noise flag", {noise, frame_err}, 2'b10);
        pulse_clr();

        // R8 framing error
        drive_frame(8'h81, 1'b0, -1, 8);
        pop_word(w, ok);
        chk(ok && w == 9'h081, "R8 word kept", w, 9'h081);
        chk(frame_err == 1'b1, "R8 framing flag", frame_err, 1);
        pulse_clr();
        clocks(300);
        chk(rx_empty == 1'b1, "R8 no extra word", rx_empty, 1);

        // R9 address-mark wake, 9-bit loopback
        loop_en = 1'b1;
        div = 13'd3;
        nine = 1'b1;
        wake_addr = 1'b1;
        clocks(600);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        chk(asleep == 1'b1, "R9 asleep after request", asleep, 1);
        push_word(9'h055);
        push_word(9'h1A5);
        push_word(9'h033);
        pop_word(w, ok);
        chk(ok && w == 9'h1A5, "R9 marked frame stored first", w, 9'h1A5);
        pop_word(w, ok);
        chk(ok && w == 9'h033, "R9 following frame stored", w, 9'h033);
        chk(asleep == 1'b0, "R9 awake", asleep, 0);
        clocks(600);
        chk(rx_empty == 1'b1, "R9 unmarked frame discarded", rx_empty, 1);

        // R10 idle-line wake, 8-bit loopback
        nine = 1'b0;
        wake_addr = 1'b0;
        clocks(200);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        push_word(9'h0C1);
        push_word(9'h0C2);
        push_word(9'h0C3);
        while (!tx_empty) @(negedge clk);
        clocks(580);
        chk(asleep == 1'b1 && rx_empty == 1'b1, "R10 asleep through traffic", {asleep, rx_empty}, 2'b11);
        clocks(600);
        chk(asleep == 1'b0, "R10 woke after idle character", asleep, 0);
        chk(rx_empty == 1'b1, "R10 sleeping frames discarded", rx_empty, 1);
        push_word(9'h05A);
        pop_word(w, ok);
        chk(ok && w == 9'h05A, "R10 receives after wake", w, 9'h05A);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule